// File: doc/BRIEF.md
# Fourteen-Function 32-bit Datapath ALU

This block is the purely combinational arithmetic and logic unit of a single-cycle integer datapath. Two operand words and a four-bit function code go in; a result word and a flag that marks an all-zero result come out in the same cycle. The unit covers bitwise logic, wrapping addition and subtraction, signed and unsigned less-than, three shift kinds and a load-upper-immediate path. It has no overflow output, and it does not decode instruction fields into the function code. A separate control decoder upstream drives the function code.

Shifts take the word to move from operand B and the distance from the low five bits of operand A. The load-upper-immediate path looks only at operand B. The signed compare flips the top bit of both operands and then compares them as unsigned numbers. The unit has no clock and no state. The four-bit code is decoded through an enumerated type, and each unused code gives a zero result.

Top module: `dp_alu`

## Requirements
- R1: Code 4'b0000 gives A AND B, 4'b0001 gives A OR B, 4'b1010 gives A XOR B, and 4'b1100 gives the inverse of (A OR B).
- R2: Codes 4'b0010 and 4'b1000 both give (A + B) modulo 2^32. A carry out of bit 31 is discarded and not reported.
- R3: Codes 4'b0110 and 4'b1001 both give (A - B) modulo 2^32. A borrow is discarded and not reported.
- R4: Code 4'b0111 gives 32'h00000001 when A < B as two's-complement numbers, and 32'h00000000 otherwise.
- R5: Code 4'b1011 gives 32'h00000001 when A < B as unsigned numbers, and 32'h00000000 otherwise.
- R6: Code 4'b0011 shifts B left by A[4:0] and code 4'b0100 shifts B right by A[4:0], both with zero fill. A[31:5] has no effect on either.
- R7: Code 4'b1101 shifts B right by A[4:0] and fills the vacated bits with copies of B[31].
- R8: Code 4'b1110 gives {B[15:0], 16'h0000}. Operand A has no effect.
- R9: The unused codes 4'b0101 and 4'b1111 give a result of 32'h00000000 for any operands.
- R10: The zero flag is 1 exactly when the 32-bit result is 32'h00000000, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; its low five bits give the shift distance |
| opnd_b | input | 32 | Second operand; the shifted word and the source for the upper-immediate path |
| op_sel | input | 4 | Function code |
| result | output | 32 | Result word |
| is_zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and an arithmetic or compare function settle in the same evaluation. This happens when a wrapping add lands on zero, when equal operands are subtracted, when a false compare returns zero, when the upper-immediate path receives a word whose low half is zero, and when an unused code is applied. Each of these cases is driven on purpose, and the bench checks the result word and the flag together against expected values worked out by hand. The sign corner cases also share a step with the unsigned views of the same operands. The pair 0x80000000 and 0x7FFFFFFF is applied to the signed and unsigned compares back to back, and the two verdicts must differ.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_SLL  = 4'b0011,
        OP_SRL  = 4'b0100,
        OP_SUB  = 4'b0110,
        OP_SLT  = 4'b0111,
        OP_ADDU = 4'b1000,
        OP_SUBU = 4'b1001,
        OP_XOR  = 4'b1010,
        OP_SLTU = 4'b1011,
        OP_NOR  = 4'b1100,
        OP_SRA  = 4'b1101,
        OP_LUI  = 4'b1110
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_ARITH = 2'b10
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_kind_e;

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         do_sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] rhs_eff;
    logic [W:0]   full;

    // Subtraction reuses the adder: invert rhs and inject a carry.
    assign rhs_eff = rhs ^ {W{do_sub}};
    assign full    = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, do_sub};
    // The carry out is dropped (R2, R3): no overflow is reported.
    assign sum     = full[W-1:0];
endmodule

// File: rtl/dp_alu_compare.sv
module dp_alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         is_signed,
    output logic         less
);
    logic [W-1:0] lhs_k;
    logic [W-1:0] rhs_k;

    // Flipping the sign bits maps two's-complement order onto unsigned order (R4).
    assign lhs_k = {lhs[W-1] ^ is_signed, lhs[W-2:0]};
    assign rhs_k = {rhs[W-1] ^ is_signed, rhs[W-2:0]};
    assign less  = (lhs_k < rhs_k);
endmodule

// File: rtl/dp_alu_shift.sv
module dp_alu_shift
    import dp_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  shift_kind_e    kind,
    output logic [W-1:0]   out
);
    always_comb begin
        unique case (kind)
            SH_LEFT:  out = val << amt;
            SH_RIGHT: out = val >> amt;
            SH_ARITH: out = W'($signed(val) >>> amt);
            default:  out = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic_kind_e  kind,
    output logic [W-1:0] out
);
    always_comb begin
        unique case (kind)
            LG_AND:  out = lhs & rhs;
            LG_OR:   out = lhs | rhs;
            LG_XOR:  out = lhs ^ rhs;
            LG_NOR:  out = ~(lhs | rhs);
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [OP_W-1:0] op_sel,
    output logic [W-1:0]    result,
    output logic            is_zero
);
    localparam int SHW  = $clog2(W);
    localparam int HALF = W / 2;

    alu_op_e     op;
    logic        do_sub;
    logic        cmp_signed;
    shift_kind_e sh_kind;
    logic_kind_e lg_kind;

    logic [W-1:0] arith_out;
    logic [W-1:0] shift_out;
    logic [W-1:0] logic_out;
    logic [W-1:0] lui_out;
    logic         less;

    assign op = alu_op_e'(op_sel);

    // Control decode for the shared subunits.
    always_comb begin
        do_sub     = 1'b0;
        cmp_signed = 1'b0;
        sh_kind    = SH_LEFT;
        lg_kind    = LG_AND;
        unique case (op)
            OP_SUB, OP_SUBU: do_sub     = 1'b1;
            OP_SLT:          cmp_signed = 1'b1;
            OP_SRL:          sh_kind    = SH_RIGHT;
            OP_SRA:          sh_kind    = SH_ARITH;
            OP_OR:           lg_kind    = LG_OR;
            OP_XOR:          lg_kind    = LG_XOR;
            OP_NOR:          lg_kind    = LG_NOR;
            default: ;
        endcase
    end

    dp_alu_addsub #(.W(W)) u_addsub (
        .lhs    (opnd_a),
        .rhs    (opnd_b),
        .do_sub (do_sub),
        .sum    (arith_out)
    );

    dp_alu_compare #(.W(W)) u_cmp (
        .lhs       (opnd_a),
        .rhs       (opnd_b),
        .is_signed (cmp_signed),
        .less      (less)
    );

    dp_alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .val  (opnd_b),
        .amt  (opnd_a[SHW-1:0]),
        .kind (sh_kind),
        .out  (shift_out)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .lhs  (opnd_a),
        .rhs  (opnd_b),
        .kind (lg_kind),
        .out  (logic_out)
    );

    // Upper-immediate path: low half of B moved to the top (R8).
    assign lui_out = {opnd_b[HALF-1:0], {HALF{1'b0}}};

    // Result select; unused codes fall to zero (R9).
    always_comb begin
        unique case (op)
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result = logic_out;
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = arith_out;
            OP_SLT, OP_SLTU:                  result = {{(W-1){1'b0}}, less};
            OP_SLL, OP_SRL, OP_SRA:           result = shift_out;
            OP_LUI:                           result = lui_out;
            default:                          result = '0;
        endcase
    end

    assign is_zero = ~|result;

    // Guards across the subunits and the result select.
    always_comb begin
        if (op_sel == 4'b0111 || op_sel == 4'b1011)
            assert_cmp_one_bit_R4: assert (result[W-1:1] == '0);
        if (op_sel == 4'b1110)
            assert_lui_low_clear_R8: assert (result[HALF-1:0] == '0);
        if (op_sel == 4'b0110 || op_sel == 4'b1001)
            assert_sub_inverse_R3: assert (W'(result + opnd_b) == opnd_a);
        if (op_sel == 4'b0010 || op_sel == 4'b1000)
            assert_add_inverse_R2: assert (W'(result - opnd_b) == opnd_a);
        if (op_sel == 4'b1101 && opnd_b[W-1])
            assert_sra_sign_kept_R7: assert (result[W-1]);
        if (op_sel == 4'b0101 || op_sel == 4'b1111)
            assert_unused_zero_R9: assert (is_zero);
        if (is_zero)
            assert_flag_means_clear_R10: assert (result[HALF-1:0] == '0);
    end
endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        is_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dp_alu u_dp_alu (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .op_sel  (op_sel),
        .result  (result),
        .is_zero (is_zero)
    );

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] exp_r, input logic exp_z);
        checks++;
        if (result !== exp_r || is_zero !== exp_z) begin
            errors++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     tag, result, is_zero, exp_r, exp_z);
        end
    endtask

    task automatic test_idle;
        apply(4'b0000, 32'h0, 32'h0);
        chk("R10 idle zero inputs", 32'h0, 1'b1);
    endtask

    task automatic test_logic;
        apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00); chk("R1 and", 32'h00F0_1200, 1'b0);
        apply(4'b0001, 32'hF0F0_1234, 32'h0FF0_FF00); chk("R1 or",  32'hFFF0_FF34, 1'b0);
        apply(4'b1010, 32'hF0F0_1234, 32'h0FF0_FF00); chk("R1 xor", 32'hFF00_ED34, 1'b0);
        apply(4'b1100, 32'hF0F0_1234, 32'h0FF0_FF00); chk("R1 nor", 32'h000F_00CB, 1'b0);
    endtask

    task automatic test_add;
        apply(4'b0010, 32'h1234_5678, 32'h1111_1111); chk("R2 add", 32'h2345_6789, 1'b0);
        apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001); chk("R2 add wrap to zero", 32'h0, 1'b1);
        apply(4'b1000, 32'h7FFF_FFFF, 32'h0000_0001); chk("R2 addu", 32'h8000_0000, 1'b0);
    endtask

    task automatic test_sub;
        apply(4'b0110, 32'd5, 32'd7);                 chk("R3 sub negative", 32'hFFFF_FFFE, 1'b0);
        apply(4'b1001, 32'h8000_0000, 32'h1);         chk("R3 subu", 32'h7FFF_FFFF, 1'b0);
        apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF); chk("R3 R10 sub equal", 32'h0, 1'b1);
    endtask

    task automatic test_compare;
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF); chk("R4 slt min vs max", 32'h1, 1'b0);
        apply(4'b1011, 32'h8000_0000, 32'h7FFF_FFFF); chk("R5 sltu min vs max", 32'h0, 1'b1);
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0);         chk("R4 slt -1 vs 0", 32'h1, 1'b0);
        apply(4'b0111, 32'h0000_0042, 32'h0000_0042); chk("R4 slt equal", 32'h0, 1'b1);
        apply(4'b1011, 32'h1, 32'hFFFF_FFFF);         chk("R5 sltu small vs big", 32'h1, 1'b0);
    endtask

    task automatic test_shift;
        apply(4'b0011, 32'hFFFF_FFE4, 32'h0000_00F1); chk("R6 sll upper A ignored", 32'h0000_0F10, 1'b0);
        apply(4'b0011, 32'd31, 32'h3);                chk("R6 sll by 31", 32'h8000_0000, 1'b0);
        apply(4'b0100, 32'd4, 32'hF000_0000);         chk("R6 srl zero fill", 32'h0F00_0000, 1'b0);
        apply(4'b0100, 32'hFFFF_FFE0, 32'h8000_0001); chk("R6 srl by 0", 32'h8000_0001, 1'b0);
    endtask

    task automatic test_sra;
        apply(4'b1101, 32'd31, 32'h8000_0000);        chk("R7 sra negative by 31", 32'hFFFF_FFFF, 1'b0);
        apply(4'b1101, 32'd4, 32'h7000_0000);         chk("R7 sra positive", 32'h0700_0000, 1'b0);
        apply(4'b1101, 32'hFFFF_FF24, 32'hF000_0010); chk("R7 sra upper A ignored", 32'hFF00_0001, 1'b0);
    endtask

    task automatic test_lui;
        apply(4'b1110, 32'hFFFF_FFFF, 32'h1234_ABCD); chk("R8 lui", 32'hABCD_0000, 1'b0);
        apply(4'b1110, 32'h1234_5678, 32'hFFFF_0000); chk("R8 R10 lui zero half", 32'h0, 1'b1);
    endtask

    task automatic test_unused;
        apply(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF); chk("R9 code 0101", 32'h0, 1'b1);
        apply(4'b1111, 32'hFFFF_FFFF, 32'h0000_0001); chk("R9 code 1111", 32'h0, 1'b1);
    endtask

    initial begin
        test_idle();
        test_logic();
        test_add();
        test_sub();
        test_compare();
        test_shift();
        test_sra();
        test_lui();
        test_unused();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule